// File: doc/BRIEF.md
# Multi-Context Folding LUT Cluster

This block is a cluster of four logic elements. Each element has a 4-input lookup table (LUT) and a flip-flop, and the cluster keeps sixteen complete configuration contexts on chip. Each context sets, for every element, the truth table, the source of each LUT input, and two more settings: whether the flip-flop captures, and whether the output is taken from the LUT or from the flip-flop. A context sequencer chooses which context is live.

Under a programmable folding level, the sequencer steps to the next context after a fixed number of LUT evaluations, at most once per cycle, and no cycles are lost between contexts. A circuit that is deeper than four LUTs can therefore be cut into slices that run one after another on the same hardware. The flip-flops hand intermediate values from one slice to the next.

Software loads the contexts while the cluster is idle. It then pulses start and waits for the one-cycle done flag. In the no-folding mode, context 0 stays live and the cluster acts like a plain LUT cluster until it is stopped.

Top module: `fold_cluster`

## Requirements
- R1: After reset, `ctx_o` is 0, `busy_o` and `done_o` are 0, all flip-flops hold 0, and all stored contexts are zero, so `data_o` is 0.
- R2: Each element's LUT output is bit `tt[{in3,in2,in1,in0}]` of its truth table. Each input `inK` is taken from the source chosen by the input's 4-bit select code: codes 0..7 pick `ext_i[code]`, codes 8..11 pick flip-flop `code-8`, and codes 12..15 give constant 0.
- R3: A configuration word is laid out as [15:0] truth table, [31:16] select codes (input K at bits 16+4K..19+4K), [32] capture enable and [33] bypass. With bypass set, `data_o[e]` is the live LUT output, combinationally. Otherwise it is the element's flip-flop.
- R4: The folding code on `fold_lvl_i` gives p: 1 gives p=1, 2 gives p=2, 3 gives p=4. While running, each context is evaluated for exactly p cycles, and contexts advance in order 0,1,2,… with no gap.
- R5: Folding code 0 means no folding. Context 0 stays active and evaluates every cycle until `stop_i`, and `done_o` does not pulse.
- R6: After the last evaluation of the context whose index equals `last_ctx_i` (sampled at start), the sequencer returns to context 0, clears `busy_o` and raises `done_o` for exactly one cycle.
- R7: A flip-flop loads its LUT output only on a running cycle whose active context has capture enable set. At all other times it holds its value, so later contexts can read it.
- R8: A configuration write (`cfg_we_i` with context index, element index and word) takes effect only on a clock edge where the cluster is idle. A write presented on any running edge, including the wrap edge, is dropped.
- R9: Evaluation begins only on a `start_i` pulse seen while idle. The first evaluation uses context 0 on the following edge. A start pulse while running has no effect.
- R10: `stop_i` while running ends the run on that edge. `busy_o` clears, `ctx_o` returns to 0 and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (idle only) |
| stop_i | input | 1 | Abort a run |
| fold_lvl_i | input | 2 | Folding code: 0 none, 1/2/3 for 1/2/4 evaluations per context |
| last_ctx_i | input | 4 | Index of the final context in a folded run |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ctx_i | input | 4 | Context index for the write |
| cfg_le_i | input | 2 | Element index for the write |
| cfg_data_i | input | 34 | Configuration word |
| ext_i | input | 8 | External data inputs |
| data_o | output | 4 | Element outputs |
| ctx_o | output | 4 | Active context index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse on completion |

## Verification
Two functions can land in the same cycle: a configuration write and the wrap edge that ends a folded run. On the wrap edge the sequencer is still running, so the write must be dropped. The bench provokes this with a single-context folded run and holds a write to the live context 0 element across that edge. That element is in bypass mode, and its function is chosen so that the dropped table and the new table give different output bits. The bench then checks that `done_o` pulses and that the combinational output still follows the old table. Finally it repeats the same write while idle, to show that the write path itself works.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned NUM_LE  = 4;
  localparam int unsigned NUM_CTX = 16;
  localparam int unsigned LUT_K   = 4;
  localparam int unsigned NUM_EXT = 8;

  localparam int unsigned CTX_W = $clog2(NUM_CTX);
  localparam int unsigned LE_W  = $clog2(NUM_LE);
  localparam int unsigned SRC_N = NUM_EXT + NUM_LE;
  localparam int unsigned SEL_W = $clog2(SRC_N + 1);
  localparam int unsigned TT_W  = 1 << LUT_K;

  typedef struct packed {
    logic                         bypass;
    logic                         cap_en;
    logic [LUT_K-1:0][SEL_W-1:0]  sel;
    logic [TT_W-1:0]              tt;
  } le_cfg_t;

  localparam int unsigned CFG_W = $bits(le_cfg_t);

  typedef enum logic [1:0] {
    FOLD_NONE = 2'd0,
    FOLD_1    = 2'd1,
    FOLD_2    = 2'd2,
    FOLD_4    = 2'd3
  } fold_e;
endpackage

// File: rtl/fc_ctx_mem.sv
module fc_ctx_mem
  import fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTX_W-1:0] wctx_i,
  input  le_cfg_t          wdata_i,
  input  logic [CTX_W-1:0] rctx_i,
  output le_cfg_t          rdata_o
);
  le_cfg_t mem_q [NUM_CTX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CTX; c++) mem_q[c] <= '0;
    end else if (we_i) begin
      mem_q[wctx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rctx_i];
endmodule

// File: rtl/fc_le.sv
module fc_le
  import fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  le_cfg_t          cfg_i,
  input  logic [SRC_N-1:0] src_i,
  input  logic             eval_i,
  output logic             ff_o,
  output logic             out_o
);
  localparam int unsigned PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] src_pad;
  logic [LUT_K-1:0] lut_addr;
  logic             lut_val;
  logic             ff_q;

  // out-of-range select codes read as constant 0
  always_comb begin
    src_pad = '0;
    src_pad[SRC_N-1:0] = src_i;
  end

  for (genvar k = 0; k < LUT_K; k++) begin : g_in
    assign lut_addr[k] = src_pad[cfg_i.sel[k]];
  end

  assign lut_val = cfg_i.tt[lut_addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ff_q <= 1'b0;
    else if (eval_i && cfg_i.cap_en)  ff_q <= lut_val;
  end

  assign ff_o  = ff_q;
  assign out_o = cfg_i.bypass ? lut_val : ff_q;
endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       fold_i,
  input  logic [CTX_W-1:0] last_i,
  output logic             run_o,
  output logic [CTX_W-1:0] ctx_o,
  output logic             done_o,
  output logic [1:0]       fold_o
);
  logic             run_q, done_q;
  logic [CTX_W-1:0] ctx_q, last_q;
  logic [1:0]       cnt_q;
  fold_e            fold_q;
  logic [1:0]       span;

  always_comb begin
    unique case (fold_q)
      FOLD_2:  span = 2'd1;
      FOLD_4:  span = 2'd3;
      default: span = 2'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ctx_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      fold_q <= FOLD_NONE;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q  <= 1'b1;
          ctx_q  <= '0;
          cnt_q  <= '0;
          fold_q <= fold_e'(fold_i);
          last_q <= last_i;
        end
      end else if (stop_i) begin
        run_q <= 1'b0;
        ctx_q <= '0;
        cnt_q <= '0;
      end else if (fold_q != FOLD_NONE) begin
        if (cnt_q == span) begin
          cnt_q <= '0;
          if (ctx_q == last_q) begin
            ctx_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ctx_q <= ctx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign run_o  = run_q;
  assign ctx_o  = ctx_q;
  assign done_o = done_q;
  assign fold_o = fold_q;
endmodule

// File: rtl/fold_cluster.sv
module fold_cluster
  import fc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [1:0]         fold_lvl_i,
  input  logic [CTX_W-1:0]   last_ctx_i,
  input  logic               cfg_we_i,
  input  logic [CTX_W-1:0]   cfg_ctx_i,
  input  logic [LE_W-1:0]    cfg_le_i,
  input  logic [CFG_W-1:0]   cfg_data_i,
  input  logic [NUM_EXT-1:0] ext_i,
  output logic [NUM_LE-1:0]  data_o,
  output logic [CTX_W-1:0]   ctx_o,
  output logic               busy_o,
  output logic               done_o
);
  logic             run;
  logic [CTX_W-1:0] ctx;
  logic [1:0]       fold_act;
  logic [NUM_LE-1:0] ff_q;
  logic [SRC_N-1:0] src;
  logic             wr_ok;

  fc_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .fold_i (fold_lvl_i),
    .last_i (last_ctx_i),
    .run_o  (run),
    .ctx_o  (ctx),
    .done_o (done_o),
    .fold_o (fold_act)
  );

  assign wr_ok = cfg_we_i && !run;
  assign src   = {ff_q, ext_i};

  for (genvar e = 0; e < NUM_LE; e++) begin : g_le
    le_cfg_t cfg;

    fc_ctx_mem i_mem (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_ok && (cfg_le_i == LE_W'(e))),
      .wctx_i (cfg_ctx_i),
      .wdata_i(le_cfg_t'(cfg_data_i)),
      .rctx_i (ctx),
      .rdata_o(cfg)
    );

    fc_le i_le (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg),
      .src_i (src),
      .eval_i(run),
      .ff_o  (ff_q[e]),
      .out_o (data_o[e])
    );
  end

  assign ctx_o  = ctx;
  assign busy_o = run;
endmodule

// File: rtl/fold_cluster_chk.sv
module fold_cluster_chk
  import fc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CTX_W-1:0]  ctx_o,
  input logic [1:0]        fold_act,
  input logic [NUM_LE-1:0] ff_q
);
  p_ctx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && (ctx_o != $past(ctx_o)) |-> ctx_o == CTX_W'($past(ctx_o) + 1'b1));

  p_nofold_ctx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (fold_act == 2'd0) |-> ctx_o == '0);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && ctx_o == '0);

  p_ff_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(ff_q));

  p_no_self_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);

  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && stop_i |=> !busy_o && ctx_o == '0 && !done_o);
endmodule

bind fold_cluster fold_cluster_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .stop_i  (stop_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ctx_o   (ctx_o),
  .fold_act(fold_act),
  .ff_q    (ff_q)
);

// File: tb/test_fold_cluster.sv
`timescale 1ns/1ps
module test_fold_cluster;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, cfg_we_i = 1'b0;
  logic [1:0]  fold_lvl_i = '0;
  logic [3:0]  last_ctx_i = '0, cfg_ctx_i = '0, ctx_o;
  logic [1:0]  cfg_le_i = '0;
  logic [33:0] cfg_data_i = '0;
  logic [7:0]  ext_i = '0;
  logic [3:0]  data_o;
  logic        busy_o, done_o;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  fold_cluster i_fold_cluster (.*);

  // {a, b, a+b mod 16}
  localparam logic [11:0] VEC [12] = '{
    12'h000, 12'h112, 12'hF10, 12'h78F, 12'h992, 12'hFFE,
    12'h5AF, 12'h3D0, 12'hC62, 12'h67D, 12'hAB5, 12'hE31
  };

  localparam int OP_AND = 0, OP_XOR2 = 1, OP_MAJ = 2, OP_XOR3 = 3, OP_F = 4;

  function automatic logic [15:0] tt_of(int op);
    logic [15:0] t = '0;
    for (int a = 0; a < 16; a++) begin
      logic i0, i1, i2;
      i0 = a[0]; i1 = a[1]; i2 = a[2];
      case (op)
        OP_AND:  t[a] = i0 & i1;
        OP_XOR2: t[a] = i0 ^ i1;
        OP_MAJ:  t[a] = (i0 & i1) | (i0 & i2) | (i1 & i2);
        OP_XOR3: t[a] = i0 ^ i1 ^ i2;
        default: t[a] = (i0 & ~i1) | i2;
      endcase
    end
    return t;
  endfunction

  function automatic logic f_ref(logic [2:0] v);
    return (v[0] & ~v[1]) | v[2];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call just after a negedge; returns just after the next negedge
  task automatic cfg_wr(input logic [3:0] c, input logic [1:0] e, input logic [15:0] tt,
                        input logic [3:0] s0, s1, s2, s3, input logic cap, byp);
    cfg_ctx_i = c; cfg_le_i = e; cfg_data_i = {byp, cap, s3, s2, s1, s0, tt}; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic add_run(input logic [3:0] a, b, s_tbl);
    logic [3:0] s;
    ext_i = {b, a}; fold_lvl_i = 2'd1; last_ctx_i = 4'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R6 done after adder", {31'd0, done_o}, 32'd1);
    s = {data_o[0], data_o[3], data_o[2], data_o[1]};
    chk("R2 R7 adder vs table", {28'd0, s}, {28'd0, s_tbl});
    chk("R2 R7 adder vs model", {28'd0, s}, {28'd0, 4'(a + b)});
  endtask

  task automatic timed(input logic [1:0] fl, input int p, input logic [3:0] last);
    int n;
    fold_lvl_i = fl; last_ctx_i = last; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = p * (int'(last) + 1);
    for (int k = 0; k < n; k++) begin
      chk("R4 context index", {28'd0, ctx_o}, 32'(k / p));
      chk("R4 busy during run", {31'd0, busy_o}, 32'd1);
      start_i = (k == 1);  // R9: restart attempt while running is ignored
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk("R6 done pulse", {31'd0, done_o}, 32'd1);
    chk("R6 idle at wrap", {27'd0, busy_o, ctx_o}, 32'd0);
    @(negedge clk_i);
    chk("R6 done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset outputs", {25'd0, data_o, ctx_o, busy_o, done_o}, 32'd0);

    // adder folded across contexts 0..3
    // codes: a_i = i, b_i = 4+i, ff_j = 8+j, const0 = 12
    cfg_wr(0, 0, tt_of(OP_AND),  0, 4, 12, 12, 1, 0);
    cfg_wr(0, 1, tt_of(OP_XOR2), 0, 4, 12, 12, 1, 0);
    cfg_wr(1, 0, tt_of(OP_MAJ),  1, 5, 8, 12, 1, 0);
    cfg_wr(1, 2, tt_of(OP_XOR3), 1, 5, 8, 12, 1, 0);
    cfg_wr(2, 0, tt_of(OP_MAJ),  2, 6, 8, 12, 1, 0);
    cfg_wr(2, 3, tt_of(OP_XOR3), 2, 6, 8, 12, 1, 0);
    cfg_wr(3, 0, tt_of(OP_XOR3), 3, 7, 8, 12, 1, 0);

    ext_i = 8'hFF;
    repeat (5) @(negedge clk_i);
    chk("R9 no evaluation before start", {27'd0, data_o, busy_o}, 32'd0);

    for (int i = 0; i < 12; i++) add_run(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);

    timed(2'd1, 1, 4'd5);
    timed(2'd2, 2, 4'd3);
    timed(2'd3, 4, 4'd1);

    // no-folding single-context function
    cfg_wr(0, 0, tt_of(OP_F), 0, 1, 2, 12, 0, 1);
    cfg_wr(0, 1, tt_of(OP_F), 0, 1, 2, 12, 1, 0);
    held = data_o[1];
    for (int v = 0; v < 8; v++) begin
      ext_i = 8'(v);
      #1;
      chk("R3 bypass combinational", {31'd0, data_o[0]}, {31'd0, f_ref(3'(v))});
      chk("R7 idle flip-flop holds", {31'd0, data_o[1]}, {31'd0, held});
      @(negedge clk_i);
    end

    fold_lvl_i = 2'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int v = 7; v >= 0; v--) begin
      ext_i = 8'(v);
      if (v == 4) begin
        cfg_ctx_i = 4'd0; cfg_le_i = 2'd0; cfg_data_i = {2'b11, 16'hCCCC, 16'hFFFF}; cfg_we_i = 1'b1;
      end else cfg_we_i = 1'b0;
      @(negedge clk_i);
      chk("R3 registered output", {31'd0, data_o[1]}, {31'd0, f_ref(3'(v))});
      chk("R5 context stays 0", {27'd0, ctx_o, busy_o}, 32'd1);
      chk("R5 no done", {31'd0, done_o}, 32'd0);
    end
    cfg_we_i = 1'b0;
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk("R10 stop to idle", {27'd0, ctx_o, busy_o}, 32'd0);
    ext_i = 8'h02;
    #1;
    chk("R8 write while running dropped", {31'd0, data_o[0]}, 32'd0);
    @(negedge clk_i);
    chk("R10 no done after stop", {31'd0, done_o}, 32'd0);

    // write held across the wrap edge of a single-context run
    fold_lvl_i = 2'd1; last_ctx_i = 4'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cfg_ctx_i = 4'd0; cfg_le_i = 2'd0; cfg_data_i = {2'b10, 16'hCCCC, 16'hFFFF}; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R6 done with last context 0", {31'd0, done_o}, 32'd1);
    chk("R8 write on wrap edge dropped", {31'd0, data_o[0]}, 32'd0);
    cfg_wr(0, 0, 16'hFFFF, 0, 1, 2, 12, 0, 1);
    chk("R8 idle write accepted", {31'd0, data_o[0]}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule